// File: doc/BRIEF.md
# Two-Step Flash Access Mode Unlock Sequencer

This block guards entry into a special flash-access mode. Software on a simple processor bus (write strobe, address, byte of data) first loads a mode selector register, then writes a magic key to a key register. Only when the key is correct and the selector holds an accepted value does the sequencer enter the mode. Every key write wipes the selector, so a failed attempt has to start again from the first step.

Once the mode is entered, the block halts the processor, disables the compute engine, pulses a reset to the flash controller and steers serial-port accesses from data RAM to flash. One selector value requests a mass erase on entry. The block then drives a one-cycle start to an external erase engine and reports busy until that engine signals done. At the end of every mass erase the security flag is cleared. The other selector value requests readback-only entry, and that entry is refused while the security flag is set. Only a system reset leaves the mode.

The controller has four states. `ST_IDLE` accepts bus writes. `ST_ENTER` lasts one cycle and pulses the flash reset and, when requested, the erase start. `ST_ERASE` waits for the erase-done input. `ST_LOCKED` holds the mode until reset. The transitions are:
- IDLE→ENTER on a successful key write.
- ENTER→ERASE when an erase was requested.
- ENTER→LOCKED when no erase was requested.
- ERASE→LOCKED on erase done.

Top module: `flash_unlock_seq`

## Requirements
- R1: After reset, `mode_rdata` is 0x00 and every output (`flash_mode`, `cpu_halt`, `ce_disable`, `flash_ctl_rst`, `spi_to_flash`, `erase_start`, `erase_busy`, `sec_flag`) is low.
- R2: A write to address 0x2080 in idle stores the data byte in the mode selector, and `mode_rdata` shows it from the cycle after the write.
- R3: Any write to the key address 0x2081 in idle clears the mode selector to 0x00, whatever the key value.
- R4: A key write of 0x96 with an accepted selector raises `flash_mode`, `cpu_halt`, `ce_disable` and `spi_to_flash` in the cycle after the write. `flash_ctl_rst` is high for that one cycle only.
- R5: A selector other than 0xD1 or 0x2E, or a key other than 0x96, does not enter the mode.
- R6: Selector 0x2E enters without erase when `sec_flag` is low, and is refused when `sec_flag` is high.
- R7: With selector 0xD1, `erase_start` pulses high for exactly the entry cycle. `erase_busy` goes high in the following cycle and stays high until `erase_done` is seen.
- R8: `sec_flag` goes low in the cycle after `erase_done` is sampled while the erase is busy.
- R9: Writes to other addresses between the selector write and the key write do not disturb the sequence.
- R10: Once entered, the mode persists and bus writes are ignored: `mode_rdata` stays unchanged and no new erase starts, until reset.
- R11: A high `sec_set` sets `sec_flag` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 16 | Bus write address |
| bus_wdata | input | 8 | Bus write data |
| sec_set | input | 1 | Sets the security flag |
| erase_done | input | 1 | Erase engine completion |
| mode_rdata | output | 8 | Current mode selector value |
| flash_mode | output | 1 | Special flash mode active |
| cpu_halt | output | 1 | Processor halt |
| ce_disable | output | 1 | Compute engine disable |
| flash_ctl_rst | output | 1 | One-cycle flash controller reset |
| spi_to_flash | output | 1 | Serial accesses steered to flash |
| erase_start | output | 1 | One-cycle mass erase start |
| erase_busy | output | 1 | Mass erase in progress |
| sec_flag | output | 1 | Security flag |

## Verification
The assertions check on every cycle the following:
- a key write leaves the selector at zero;
- the mode never rises except right after a correct key write;
- once entered, the mode never drops;
- the erase start never lasts two cycles and is always followed by busy;
- erase completion clears the security flag.

Only the bench scenarios can show other behaviour:
- which selector and key combinations succeed or fail, including readback refusal under the security flag;
- that unrelated writes leave an armed selector intact;
- that bus writes after entry are ignored.

// File: rtl/flash_unlock_pkg.sv
package flash_unlock_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENTER  = 2'd1,
        ST_ERASE  = 2'd2,
        ST_LOCKED = 2'd3
    } fu_state_t;
endpackage

// File: rtl/flash_unlock_regs.sv
module flash_unlock_regs #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h2080,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 16'h2081,
    parameter logic [DATA_W-1:0] KEY_VAL  = 8'h96,
    parameter logic [DATA_W-1:0] SEL_WIPE = 8'hD1,
    parameter logic [DATA_W-1:0] SEL_READ = 8'h2E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_open,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sec_flag,
    output logic [DATA_W-1:0] sel_q,
    output logic              unlock,
    output logic              wipe_sel
);
    logic sel_wr;
    logic key_wr;
    logic sel_ok;

    assign sel_wr   = wr_open && we && (addr == SEL_ADDR);
    assign key_wr   = wr_open && we && (addr == KEY_ADDR);
    assign wipe_sel = (sel_q == SEL_WIPE);
    assign sel_ok   = wipe_sel || ((sel_q == SEL_READ) && !sec_flag);
    assign unlock   = key_wr && (wdata == KEY_VAL) && sel_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (key_wr) begin
            sel_q <= '0;
        end else if (sel_wr) begin
            sel_q <= wdata;
        end
    end

    // R3
    key_clears_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_open && we && addr == KEY_ADDR) |=> (sel_q == '0));
endmodule

// File: rtl/flash_unlock_fsm.sv
module flash_unlock_fsm
    import flash_unlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic unlock,
    input  logic wipe_sel,
    input  logic erase_done,
    input  logic sec_set,
    output logic wr_open,
    output logic active,
    output logic ctl_rst,
    output logic wipe_start,
    output logic wipe_busy,
    output logic sec_q
);
    fu_state_t state_q, state_d;
    logic      wipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wipe_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (unlock) begin
                wipe_q <= wipe_sel;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (unlock) state_d = ST_ENTER;
            ST_ENTER:  state_d = wipe_q ? ST_ERASE : ST_LOCKED;
            ST_ERASE:  if (erase_done) state_d = ST_LOCKED;
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_open    = 1'b0;
        active     = 1'b1;
        ctl_rst    = 1'b0;
        wipe_start = 1'b0;
        wipe_busy  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_open = 1'b1;
                active  = 1'b0;
            end
            ST_ENTER: begin
                ctl_rst    = 1'b1;
                wipe_start = wipe_q;
            end
            ST_ERASE:  wipe_busy = 1'b1;
            ST_LOCKED: ;
            default:   active = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= 1'b0;
        end else if (state_q == ST_ERASE && erase_done) begin
            sec_q <= 1'b0;
        end else if (sec_set) begin
            sec_q <= 1'b1;
        end
    end

    // R7
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_start |=> !wipe_start);
    // R7
    start_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_start |=> wipe_busy);
    // R8
    sec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_busy && erase_done) |=> !sec_q);
    // R10
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> active);
endmodule

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h2080,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 16'h2081,
    parameter logic [DATA_W-1:0] KEY_VAL  = 8'h96,
    parameter logic [DATA_W-1:0] SEL_WIPE = 8'hD1,
    parameter logic [DATA_W-1:0] SEL_READ = 8'h2E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              sec_set,
    input  logic              erase_done,
    output logic [DATA_W-1:0] mode_rdata,
    output logic              flash_mode,
    output logic              cpu_halt,
    output logic              ce_disable,
    output logic              flash_ctl_rst,
    output logic              spi_to_flash,
    output logic              erase_start,
    output logic              erase_busy,
    output logic              sec_flag
);
    logic wr_open;
    logic unlock;
    logic wipe_sel;
    logic active;

    flash_unlock_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_ADDR(SEL_ADDR), .KEY_ADDR(KEY_ADDR),
        .KEY_VAL(KEY_VAL), .SEL_WIPE(SEL_WIPE), .SEL_READ(SEL_READ)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_open(wr_open), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .sec_flag(sec_flag), .sel_q(mode_rdata),
        .unlock(unlock), .wipe_sel(wipe_sel)
    );

    flash_unlock_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .unlock(unlock), .wipe_sel(wipe_sel),
        .erase_done(erase_done), .sec_set(sec_set), .wr_open(wr_open),
        .active(active), .ctl_rst(flash_ctl_rst), .wipe_start(erase_start),
        .wipe_busy(erase_busy), .sec_q(sec_flag)
    );

    assign flash_mode   = active;
    assign cpu_halt     = active;
    assign ce_disable   = active;
    assign spi_to_flash = active;

    // R4
    entry_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_mode) |-> $past(bus_we && bus_addr == KEY_ADDR && bus_wdata == KEY_VAL));
endmodule

// File: tb/sim_flash_unlock_seq.sv
module sim_flash_unlock_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        sec_set = 1'b0;
    logic        erase_done = 1'b0;
    logic [7:0]  mode_rdata;
    logic        flash_mode, cpu_halt, ce_disable, flash_ctl_rst, spi_to_flash;
    logic        erase_start, erase_busy, sec_flag;
    int          checks = 0;
    int          errors = 0;

    localparam logic [15:0] A_SEL = 16'h2080;
    localparam logic [15:0] A_KEY = 16'h2081;

    always #4 clk = ~clk;

    flash_unlock_seq u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .sec_set(sec_set), .erase_done(erase_done),
        .mode_rdata(mode_rdata), .flash_mode(flash_mode), .cpu_halt(cpu_halt),
        .ce_disable(ce_disable), .flash_ctl_rst(flash_ctl_rst),
        .spi_to_flash(spi_to_flash), .erase_start(erase_start),
        .erase_busy(erase_busy), .sec_flag(sec_flag)
    );

    function automatic bit fn_enter(logic [7:0] sel, logic [7:0] key, bit sec);
        return (key == 8'h96) && ((sel == 8'hD1) || (sel == 8'h2E && !sec));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0; sec_set = 1'b0; erase_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse_sec();
        sec_set = 1'b1;
        @(negedge clk);
        sec_set = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] sel_m;
        bit         sec_m;
        bit         ent;
        process::self().srandom(32'd7);

        do_reset();
        // R1 reset state
        check("R1 mode_rdata", mode_rdata, 8'h00);
        check("R1 outputs", {flash_mode, cpu_halt, ce_disable, flash_ctl_rst,
              spi_to_flash, erase_start, erase_busy, sec_flag}, 8'h00);

        // R11 security set
        pulse_sec();
        check("R11 sec_flag", sec_flag, 1);
        // R2 selector write
        wr(A_SEL, 8'hD1);
        check("R2 mode_rdata", mode_rdata, 8'hD1);
        // R9 unrelated write
        wr(16'h1234, 8'h55);
        check("R9 sel kept", mode_rdata, 8'hD1);
        wr(A_KEY, 8'h96);
        // R4 entry outputs
        check("R4 mode/halt/ce/spi", {flash_mode, cpu_halt, ce_disable, spi_to_flash}, 4'hF);
        check("R4 flash_ctl_rst", flash_ctl_rst, 1);
        check("R7 erase_start", erase_start, 1);
        check("R3 sel cleared", mode_rdata, 8'h00);
        @(negedge clk);
        check("R4 rst one cycle", flash_ctl_rst, 0);
        check("R7 start one cycle", erase_start, 0);
        check("R7 busy", erase_busy, 1);
        repeat (3) @(negedge clk);
        check("R7 busy held", erase_busy, 1);
        check("R8 sec before done", sec_flag, 1);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        check("R7 busy ends", erase_busy, 0);
        check("R8 sec cleared", sec_flag, 0);
        // R10 writes ignored after entry
        wr(A_SEL, 8'hD1);
        check("R10 sel frozen", mode_rdata, 8'h00);
        wr(A_KEY, 8'h96);
        check("R10 no restart", erase_start, 0);
        check("R10 mode held", flash_mode, 1);

        // R6 readback refused with security set
        do_reset();
        pulse_sec();
        wr(A_SEL, 8'h2E);
        wr(A_KEY, 8'h96);
        check("R6 refused", flash_mode, 0);
        check("R3 sel cleared on fail", mode_rdata, 8'h00);
        // R6 readback allowed without security
        do_reset();
        wr(A_SEL, 8'h2E);
        wr(A_KEY, 8'h96);
        check("R6 entered", flash_mode, 1);
        check("R6 no erase start", erase_start, 0);
        @(negedge clk);
        check("R6 no busy", erase_busy, 0);
        check("R6 still in mode", flash_mode, 1);

        // R5 bad selector / bad key
        do_reset();
        wr(A_SEL, 8'h55);
        wr(A_KEY, 8'h96);
        check("R5 bad sel", flash_mode, 0);
        wr(A_SEL, 8'hD1);
        wr(A_KEY, 8'h97);
        check("R5 bad key", flash_mode, 0);
        check("R3 cleared by bad key", mode_rdata, 8'h00);
        wr(A_KEY, 8'h96);
        check("R3 key alone fails", flash_mode, 0);

        // random trials against bench model
        for (int t = 0; t < 150; t++) begin
            do_reset();
            sel_m = 8'h00;
            sec_m = ($urandom % 3) == 0;
            if (sec_m) pulse_sec();
            for (int k = 0; k < 12; k++) begin
                logic [15:0] a;
                logic [7:0]  d;
                logic [7:0]  prev;
                case ($urandom % 4)
                    0, 3: a = A_SEL;
                    1:    a = A_KEY;
                    default: a = 16'h3000 + 16'($urandom % 16);
                endcase
                case ($urandom % 4)
                    0: d = 8'hD1;
                    1: d = 8'h2E;
                    2: d = 8'h96;
                    default: d = 8'($urandom);
                endcase
                prev = sel_m;
                ent = 1'b0;
                if (a == A_KEY) begin
                    ent = fn_enter(sel_m, d, sec_m);
                    sel_m = 8'h00;
                end else if (a == A_SEL) begin
                    sel_m = d;
                end
                wr(a, d);
                check("R2/R3/R9 random sel", mode_rdata, sel_m);
                check("R4/R5/R6 random entry", flash_mode, ent);
                if (ent) begin
                    check("R7 random start", erase_start, prev == 8'hD1);
                    break;
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule